// File: doc/BRIEF.md
# Shift-and-Operate ALU with Condition Flags

This block is the arithmetic slice of a processor datapath. Each accepted operation takes two operands, sends the second through a barrel shifter, combines the shifted value with the first operand in one cycle, and produces a result together with next-state values for four condition flags: negative (N), zero (Z), carry (C) and overflow (V). The caller supplies the current flags. The block returns either the updated flags or the same flags unchanged, depending on the operation and on a set-flags enable.

Operations enter on a valid/ready stream and leave on a second valid/ready stream after one register stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no loss and no duplication. While `out_valid` is high and `out_ready` is low, every output field holds its value. A result-write strobe travels with each result. It is low for the compare and test operations: they only produce flags, and the datapath must not write their result to a register.

Top module: `alu_flag_unit`

## Requirements
- R1: Whenever flags are updated, N equals bit 31 of the result. Flags are packed {N,Z,C,V} in bits 3..0 of `in_flags` and `out_flags`.
- R2: Whenever flags are updated, Z is 1 exactly when all 32 result bits are zero.
- R3: For ADD (op 0) and CMN (op 4, compare-by-adding), C is the unsigned carry out of bit 31 of operand A plus the shifted operand B.
- R4: For SUB (op 1, A-B), RSB (op 2, B-A) and CMP (op 3, A-B), C is 1 when no borrow occurs and 0 when a borrow occurs.
- R5: For the logical and move operations AND 5, ORR 6, EOR 7, BIC 8 (A and not B), MOV 9, MVN 10, TST 11 and TEQ 12, a nonzero shift amount sets C to the last bit shifted out of B. V keeps its input value. Codes 13 to 15 behave as MOV.
- R6: A shift amount of 0 passes B through unchanged. For the logical and move operations it leaves both C and V at their input values.
- R7: For the five arithmetic operations, V is 1 exactly when the two's-complement result overflows.
- R8: When `in_set_flags` is low and the operation is not a compare or test, `out_flags` equals `in_flags`.
- R9: CMP, CMN, TST and TEQ update the flags whatever the value of `in_set_flags`. They drive `out_wr` low. All other operations drive `out_wr` high.
- R10: The shift type selects how B is shifted by `in_shift_amt`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The shift and the operation complete together in the same cycle.
- R11: An accepted operation appears on the output one clock later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Operation code (see R3-R5, R9) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B, sent through the shifter |
| in_shift_type | input | 2 | Shift type (R10) |
| in_shift_amt | input | 5 | Shift amount, 0 to 31 |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| in_set_flags | input | 1 | Allow flag update for non-compare operations |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Operation result |
| out_flags | output | 4 | Next flags {N,Z,C,V} |
| out_wr | output | 1 | Result should be written back |

## Verification
The bench builds the block with its default 32-bit width and a 5-bit shift amount. At that width the sign-bit overflow cases, the full-word carry and borrow cases, and shifts of 1 and 31 positions can be aimed at directly with hand-picked operands. The random phase toggles consumer back-pressure, so operations are accepted while the output stage is stalled, while it drains, and while it is empty.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_RSB = 4'd2,
    OP_CMP = 4'd3,
    OP_CMN = 4'd4,
    OP_AND = 4'd5,
    OP_ORR = 4'd6,
    OP_EOR = 4'd7,
    OP_BIC = 4'd8,
    OP_MOV = 4'd9,
    OP_MVN = 4'd10,
    OP_TST = 4'd11,
    OP_TEQ = 4'd12,
    OP_R13 = 4'd13,
    OP_R14 = 4'd14,
    OP_R15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  // bit positions inside the 4-bit flag vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/alu_shift_stage.sv
module alu_shift_stage
  import alu_pkg::*;
#(
  parameter int W = 32,
  parameter int S = 1
) (
  input  logic [W-1:0] x,
  input  shift_e       stype,
  input  logic         en,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);

  logic [W-1:0] moved;
  logic         lost;

  always_comb begin
    case (stype)
      SH_LSL: begin
        moved = {x[W-1-S:0], {S{1'b0}}};
        lost  = x[W-S];
      end
      SH_LSR: begin
        moved = {{S{1'b0}}, x[W-1:S]};
        lost  = x[S-1];
      end
      SH_ASR: begin
        moved = {{S{x[W-1]}}, x[W-1:S]};
        lost  = x[S-1];
      end
      default: begin
        moved = {x[S-1:0], x[W-1:S]};
        lost  = x[S-1];
      end
    endcase
    y    = en ? moved : x;
    cout = en ? lost  : cin;
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  shift_e         stype,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout,
  output logic           cout,
  output logic           hit
);

  logic [SHW:0][W-1:0] lvl;
  logic [SHW:0]        car;

  assign lvl[0] = din;
  assign car[0] = 1'b0;

  // one stage per amount bit; the last active stage decides the carry
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    alu_shift_stage #(.W(W), .S(1 << k)) u_stage (
      .x    (lvl[k]),
      .stype(stype),
      .en   (amt[k]),
      .cin  (car[k]),
      .y    (lvl[k+1]),
      .cout (car[k+1])
    );
  end

  assign dout = lvl[SHW];
  assign cout = car[SHW];
  assign hit  = |amt;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_sh,
  input  logic         sh_c,
  input  logic         sh_hit,
  input  logic [3:0]   flags_in,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic [3:0]   flags_nx,
  output logic         wr
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   sum;
  logic         is_arith, is_cmp;

  always_comb begin
    x   = a;
    y   = b_sh;
    cin = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin
        y   = ~b_sh;
        cin = 1'b1;
      end
      OP_RSB: begin
        x   = b_sh;
        y   = ~a;
        cin = 1'b1;
      end
      default: ;
    endcase
    sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  end

  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB) ||
                    (op == OP_CMP) || (op == OP_CMN);
  assign is_cmp   = (op == OP_CMP) || (op == OP_CMN) ||
                    (op == OP_TST) || (op == OP_TEQ);
  assign wr       = !is_cmp;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_RSB, OP_CMP, OP_CMN: result = sum[W-1:0];
      OP_AND, OP_TST:                         result = a & b_sh;
      OP_ORR:                                 result = a | b_sh;
      OP_EOR, OP_TEQ:                         result = a ^ b_sh;
      OP_BIC:                                 result = a & ~b_sh;
      OP_MVN:                                 result = ~b_sh;
      default:                                result = b_sh;
    endcase
  end

  always_comb begin
    flags_nx = flags_in;
    if (set_flags || is_cmp) begin
      flags_nx[FLAG_N] = result[W-1];
      flags_nx[FLAG_Z] = (result == '0);
      if (is_arith) begin
        flags_nx[FLAG_C] = sum[W];
        flags_nx[FLAG_V] = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
      end else if (sh_hit) begin
        flags_nx[FLAG_C] = sh_c;
      end
    end
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [1:0]       in_shift_type,
  input  logic [SHW-1:0]   in_shift_amt,
  input  logic [3:0]       in_flags,
  input  logic             in_set_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic [3:0]       out_flags,
  output logic             out_wr
);

  logic [WIDTH-1:0] b_sh, res_c;
  logic             sh_c, sh_hit, wr_c;
  logic [3:0]       flags_c;
  logic             take;

  alu_shifter #(.W(WIDTH), .SHW(SHW)) u_shift (
    .din  (in_b),
    .stype(shift_e'(in_shift_type)),
    .amt  (in_shift_amt),
    .dout (b_sh),
    .cout (sh_c),
    .hit  (sh_hit)
  );

  alu_core #(.W(WIDTH)) u_core (
    .op       (alu_op_e'(in_op)),
    .a        (in_a),
    .b_sh     (b_sh),
    .sh_c     (sh_c),
    .sh_hit   (sh_hit),
    .flags_in (in_flags),
    .set_flags(in_set_flags),
    .result   (res_c),
    .flags_nx (flags_c),
    .wr       (wr_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_wr     <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= res_c;
        out_flags  <= flags_c;
        out_wr     <= wr_c;
      end
    end
  end

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int WIDTH = 32,
  parameter int SHW   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [SHW-1:0]   in_shift_amt,
  input logic [3:0]       in_flags,
  input logic             in_set_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [3:0]       out_flags,
  input logic             out_wr
);

  logic fire, cmp_op, logic_op;
  assign fire     = in_valid && in_ready;
  assign cmp_op   = (in_op == 4'd3) || (in_op == 4'd4) ||
                    (in_op == 4'd11) || (in_op == 4'd12);
  assign logic_op = (in_op >= 4'd5);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_flags) && $stable(out_wr));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_cmp_nowr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmp_op |=> !out_wr);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_set_flags && !cmp_op |=> out_flags == $past(in_flags));

  // R1 and R2: sign and zero flags follow the produced result
  assert_nz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_set_flags || cmp_op) |=>
      out_flags[3] == out_result[WIDTH-1] &&
      out_flags[2] == (out_result == '0));

  assert_noshift_cv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && logic_op && in_shift_amt == '0 |=>
      out_flags[1:0] == $past(in_flags[1:0]));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_shift_amt(in_shift_amt),
  .in_flags    (in_flags),
  .in_set_flags(in_set_flags),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_flags   (out_flags),
  .out_wr      (out_wr)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_shift_type = '0;
  logic [4:0]  in_shift_amt = '0;
  logic [3:0]  in_flags = '0;
  logic        in_set_flags = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_flags;
  logic        out_wr;

  int checks = 0;
  int failures = 0;
  bit bp_en = 1'b0;
  int bp_cnt = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    logic        wr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shift_type(in_shift_type),
    .in_shift_amt(in_shift_amt), .in_flags(in_flags),
    .in_set_flags(in_set_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .out_wr(out_wr)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [1:0] st,
                                 input logic [4:0] n, input logic [3:0] fl,
                                 input logic sf, input string tag);
    exp_t e;
    logic [31:0] bs;
    logic        sc;
    logic [32:0] w;
    longint      sa, sb2, t;
    logic        ar, cmp, c, v;
    bs = b; sc = 1'b0;
    case (st)
      2'd0: begin w = {1'b0, b} << n; bs = w[31:0]; sc = w[32]; end
      2'd1: begin w = {b, 1'b0} >> n; bs = w[32:1]; sc = w[0]; end
      2'd2: begin w = 33'($signed({b, 1'b0}) >>> n); bs = w[32:1]; sc = w[0]; end
      default: begin bs = (b >> n) | (b << (6'd32 - {1'b0, n})); sc = bs[31]; end
    endcase
    sa = longint'($signed(a));
    sb2 = longint'($signed(bs));
    ar = (op <= 4'd4);
    cmp = (op == 4'd3) || (op == 4'd4) || (op == 4'd11) || (op == 4'd12);
    c = fl[1]; v = fl[0];
    case (op)
      4'd0, 4'd4: begin
        w = {1'b0, a} + {1'b0, bs}; e.res = w[31:0]; c = w[32]; t = sa + sb2;
      end
      4'd1, 4'd3: begin e.res = a - bs; c = (a >= bs); t = sa - sb2; end
      4'd2: begin e.res = bs - a; c = (bs >= a); t = sb2 - sa; end
      4'd5, 4'd11: begin e.res = a & bs; t = 0; end
      4'd6: begin e.res = a | bs; t = 0; end
      4'd7, 4'd12: begin e.res = a ^ bs; t = 0; end
      4'd8: begin e.res = a & ~bs; t = 0; end
      4'd10: begin e.res = ~bs; t = 0; end
      default: begin e.res = bs; t = 0; end
    endcase
    if (ar) v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    else if (n != 0) c = sc;
    if (sf || cmp) e.flg = {e.res[31], e.res == 32'd0, c, v};
    else e.flg = fl;
    e.wr = !cmp;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [1:0] st,
                      input logic [4:0] n, input logic [3:0] fl,
                      input logic sf, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shift_type = st;
    in_shift_amt = n; in_flags = fl; in_set_flags = sf;
    sb.push_back(model(op, a, b, st, n, fl, sf, tag));
    while (!in_ready) begin
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    out_ready = !bp_en || (bp_cnt % 3 != 0) && (bp_cnt % 7 != 2);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected output: got result with empty queue, expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_result == e.res, e.tag,
              $sformatf("result got %h expected %h", out_result, e.res));
        check(out_flags == e.flg, e.tag,
              $sformatf("flags got %b expected %b", out_flags, e.flg));
        check(out_wr == e.wr, e.tag,
              $sformatf("wr got %b expected %b", out_wr, e.wr));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "WATCHDOG", "timeout got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R11", $sformatf("reset out_valid got %b expected 0", out_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11", $sformatf("idle in_ready got %b expected 1", in_ready));

    // R3 carry and R2 zero: all-ones plus one
    send(4'd0, 32'hFFFF_FFFF, 32'd1, 2'd0, 5'd0, 4'b0000, 1'b1, "R3");
    // R7 signed overflow, R1 negative result
    send(4'd0, 32'h7FFF_FFFF, 32'd1, 2'd0, 5'd0, 4'b0000, 1'b1, "R7");
    // R4 no borrow, then borrow
    send(4'd1, 32'd5, 32'd3, 2'd0, 5'd0, 4'b0000, 1'b1, "R4");
    send(4'd1, 32'd3, 32'd5, 2'd0, 5'd0, 4'b0010, 1'b1, "R4");
    send(4'd2, 32'd3, 32'd5, 2'd0, 5'd0, 4'b0000, 1'b1, "R4");
    // R7 subtract overflow: most negative minus one
    send(4'd1, 32'h8000_0000, 32'd1, 2'd0, 5'd0, 4'b0000, 1'b1, "R7");
    // R9 compare with set_flags low, equal operands
    send(4'd3, 32'd77, 32'd77, 2'd0, 5'd0, 4'b1001, 1'b0, "R9");
    send(4'd11, 32'hF0, 32'h0F, 2'd0, 5'd0, 4'b0011, 1'b0, "R9");
    send(4'd4, 32'hFFFF_FFFF, 32'd1, 2'd0, 5'd0, 4'b0000, 1'b0, "R9");
    // R5 last bit shifted out, V held
    send(4'd5, 32'hFFFF_FFFF, 32'h8000_0000, 2'd0, 5'd1, 4'b0001, 1'b1, "R5");
    send(4'd9, 32'd0, 32'h0000_0008, 2'd1, 5'd4, 4'b0000, 1'b1, "R5");
    send(4'd9, 32'd0, 32'h0000_0001, 2'd0, 5'd31, 4'b0010, 1'b1, "R5");
    // R10 each shift type
    send(4'd9, 32'd0, 32'h8000_00F0, 2'd2, 5'd4, 4'b0000, 1'b1, "R10");
    send(4'd9, 32'd0, 32'h0000_00F1, 2'd3, 5'd4, 4'b0000, 1'b1, "R10");
    send(4'd0, 32'd1, 32'h0000_0003, 2'd0, 5'd2, 4'b0000, 1'b1, "R10");
    // R6 zero amount: pass-through and C,V held
    send(4'd9, 32'd0, 32'h8000_0001, 2'd1, 5'd0, 4'b0011, 1'b1, "R6");
    send(4'd10, 32'd0, 32'hFFFF_FFFF, 2'd0, 5'd0, 4'b0010, 1'b1, "R6");
    // R8 set_flags low on arithmetic that would change every flag
    send(4'd0, 32'hFFFF_FFFF, 32'd1, 2'd0, 5'd0, 4'b1001, 1'b0, "R8");
    send(4'd5, 32'h0, 32'h8000_0000, 2'd0, 5'd1, 4'b0100, 1'b0, "R8");

    // random phase under back-pressure
    bp_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (i % 5 == 0) ? ra : $urandom;
      send(4'($urandom % 16), ra, rb, 2'($urandom), 5'($urandom),
           4'($urandom), 1'($urandom), "R11");
    end
    bp_en = 1'b0;

    for (int k = 0; k < 50 && sb.size() != 0; k++) @(posedge clk);
    check(sb.size() == 0, "R11",
          $sformatf("pending got %0d expected 0", sb.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule